// File: doc/BRIEF.md
# Two-Breakpoint Trigger and Action Controller

This block watches a processor's program-fetch bus and its data bus, combines two address/data comparators into one trigger condition, counts qualified occurrences of that condition, and raises a debug action when the chosen occurrence arrives. The first comparator matches an address and filters it by bus and access type. The second comparator has no qualifiers. It matches a program-fetch address and supplies raw data-value and masked data comparisons.

A debugger programs the block through a simple register write port. It writes two compare addresses, a data value, a bit mask and an occurrence count. It then writes a control word that selects the trigger mode and the action, and sets the arm bit. When the Nth qualified event arrives, the block does one of four things:

- It halts the core, with a sticky output.
- It halts the trace FIFO, with a sticky output.
- It pulses an interrupt request.
- It toggles a debug-event pin and rearms itself, so triggering continues without debugger help.

Top module: `bkpt_trigger`

## Requirements
- R1: After synchronous reset, halt_core, fifo_halt, irq and de_pin are all 0, and with mode 0 (off) no bus activity raises any output. Register addresses: 0 = compare address A, 1 = compare address B, 2 = data value, 3 = data mask, 4 = control, 5 = occurrence count, 6 = clear (a write of any value clears the sticky outputs).
- R2: The control word holds bus select in bits 1:0 and access select in bits 3:2. Bus select bit 0 enables the program bus, where a fetch counts as a read. Bus select bit 1 enables the data bus. Access select bit 0 accepts reads and access select bit 1 accepts writes. Breakpoint 1 hits only when an enabled bus carries address A with an accepted access type, so access select 00 never hits.
- R3: Breakpoint 2 matches a program fetch at address B regardless of the bus select and access select bits. A data-bus access at address B does not match it. Mode 1 (control bits 6:4 = 1) fires on breakpoint 1 or breakpoint 2.
- R4: Mode 2 fires when breakpoint 1 hits in the same cycle that the data bus value equals the data value register exactly.
- R5: Mode 3 fires when breakpoint 1 hits and the data bus agrees with the data value register on every bit set in the mask register. Bits clear in the mask are ignored.
- R6: Mode 4 is a sequence. A breakpoint 1 hit makes the block pending, and a later breakpoint 2 hit while pending completes one event. A breakpoint 2 hit while not pending is ignored. If both hit in the same cycle while not pending, only the first step is taken. Disarming clears the pending state.
- R7: Arming (a 0-to-1 change of control bit 12) loads the occurrence count. Each qualified event decrements it, and the action fires on the event that brings it to zero. That is the Nth event for count N, and a count of 0 behaves as 1. Events are accepted from the second cycle after the arming write.
- R8: Action 00 (control bits 9:8) sets halt_core one cycle after the firing event. halt_core stays set until a clear-register write.
- R9: Action 01 sets fifo_halt one cycle after the firing event. fifo_halt stays set until a clear-register write.
- R10: Action 10 drives irq high for exactly one cycle, one cycle after the firing event.
- R11: Action 11 toggles de_pin on each firing. It reloads the count and returns the sequence state to idle, so every Nth event fires again.
- R12: With actions 00, 01 and 10 the block fires at most once per arming. Further events are ignored until the block is disarmed and armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | DW | Register write data |
| pab | input | AW | Program fetch address |
| fetch_stb | input | 1 | Program fetch valid |
| xab | input | AW | Data bus address |
| xdb | input | DW | Data bus value |
| rd_stb | input | 1 | Data read strobe |
| wr_stb | input | 1 | Data write strobe |
| halt_core | output | 1 | Sticky core halt request |
| fifo_halt | output | 1 | Sticky trace FIFO halt |
| irq | output | 1 | One-cycle interrupt request |
| de_pin | output | 1 | Debug-event pin, toggled in rearm mode |

## Verification
The assertions check several behaviours on every cycle:

- The sticky outputs hold until a clear write, and irq never lasts two cycles.
- de_pin moves only under the rearm action.
- The pending sequence state drops while the block is disarmed, and a non-rearm firing is never followed by another.
- The counter steps down by exactly one per event, and access select 00 never produces a breakpoint 1 hit.

Only the bench scenarios can show the rest:

- which Nth event fires for each count,
- the full qualifier and mask truth tables,
- the ordering rules of the sequence mode,
- the de_pin pattern across repeated rearmed firings.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    // Register addresses on the configuration port
    localparam logic [2:0] REG_ADDR_A = 3'd0;
    localparam logic [2:0] REG_ADDR_B = 3'd1;
    localparam logic [2:0] REG_DVAL   = 3'd2;
    localparam logic [2:0] REG_DMASK  = 3'd3;
    localparam logic [2:0] REG_CTRL   = 3'd4;
    localparam logic [2:0] REG_COUNT  = 3'd5;
    localparam logic [2:0] REG_CLEAR  = 3'd6;

    // Trigger modes (control bits 6:4); other codes mean off
    localparam logic [2:0] MODE_OFF   = 3'd0;
    localparam logic [2:0] MODE_PROG2 = 3'd1;
    localparam logic [2:0] MODE_DVAL  = 3'd2;
    localparam logic [2:0] MODE_DMASK = 3'd3;
    localparam logic [2:0] MODE_SEQ   = 3'd4;

    typedef enum logic [1:0] {
        ACT_HALT  = 2'b00,
        ACT_FIFO  = 2'b01,
        ACT_IRQ   = 2'b10,
        ACT_REARM = 2'b11
    } act_e;

    // Control word layout, 16 bits
    typedef struct packed {
        logic [2:0] spare_hi;
        logic       arm;
        logic [1:0] spare_mid;
        logic [1:0] act;
        logic       spare_lo;
        logic [2:0] mode;
        logic [1:0] acc;
        logic [1:0] bsel;
    } ctrl_t;

    // Raw comparator results for one cycle
    typedef struct packed {
        logic bp1;
        logic bp2_fetch;
        logic val_eq;
        logic mask_eq;
    } hits_t;

    function automatic logic access_ok(logic [1:0] acc, logic rd, logic wr);
        return (rd & acc[0]) | (wr & acc[1]);
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] addr_a,
    output logic [AW-1:0] addr_b,
    output logic [DW-1:0] dval,
    output logic [DW-1:0] dmask,
    output ctrl_t         ctrl,
    output logic [CW-1:0] count,
    output logic          clr
);

    localparam int CTRL_W = $bits(ctrl_t);

    assign clr = we && (addr == REG_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_a <= '0;
            addr_b <= '0;
            dval   <= '0;
            dmask  <= '0;
            ctrl   <= '0;
            count  <= '0;
        end else if (we) begin
            case (addr)
                REG_ADDR_A: addr_a <= wdata[AW-1:0];
                REG_ADDR_B: addr_b <= wdata[AW-1:0];
                REG_DVAL:   dval   <= wdata;
                REG_DMASK:  dmask  <= wdata;
                REG_CTRL:   ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
                REG_COUNT:  count  <= wdata[CW-1:0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [AW-1:0] pab,
    input  logic          fetch_stb,
    input  logic [AW-1:0] xab,
    input  logic [DW-1:0] xdb,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] dval,
    input  logic [DW-1:0] dmask,
    input  logic [1:0]    bsel,
    input  logic [1:0]    acc,
    output hits_t         hits
);

    logic prog_hit1, data_hit1;

    // Breakpoint 1: qualified by bus select and access type
    assign prog_hit1 = bsel[0] & fetch_stb & (pab == addr_a) & acc[0];
    assign data_hit1 = bsel[1] & (xab == addr_a) & access_ok(acc, rd_stb, wr_stb);

    always_comb begin
        hits.bp1       = prog_hit1 | data_hit1;
        // Breakpoint 2: unqualified
        hits.bp2_fetch = fetch_stb & (pab == addr_b);
        hits.val_eq    = (xdb == dval);
        hits.mask_eq   = ((xdb ^ dval) & dmask) == '0;
    end

    // R2: access select 00 blocks breakpoint 1 on both buses
    always_comb begin
        if (acc == 2'b00) begin
            a_r2_acc_off: assert (!(prog_hit1 | data_hit1));
        end
    end

endmodule

// File: rtl/bkpt_core.sv
module bkpt_core
    import bkpt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic [CW-1:0] count,
    input  logic          clr,
    input  hits_t         hits,
    output logic          halt_core,
    output logic          fifo_halt,
    output logic          irq,
    output logic          de_pin
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic          arm_q, done_q, pend_q;
    logic [CW-1:0] cnt_q;
    logic          arm_rise, active, raw_ev, qev, last, fire;
    logic [CW-1:0] load_val;
    act_e          act;

    assign act      = act_e'(ctrl.act);
    assign arm_rise = ctrl.arm & ~arm_q;
    assign active   = ctrl.arm & arm_q & ~done_q;
    assign load_val = (count == '0) ? CNT_ONE : count;

    always_comb begin
        case (ctrl.mode)
            MODE_PROG2: raw_ev = hits.bp1 | hits.bp2_fetch;
            MODE_DVAL:  raw_ev = hits.bp1 & hits.val_eq;
            MODE_DMASK: raw_ev = hits.bp1 & hits.mask_eq;
            MODE_SEQ:   raw_ev = pend_q & hits.bp2_fetch;
            default:    raw_ev = 1'b0;
        endcase
    end

    assign qev  = active & raw_ev;
    assign last = (cnt_q <= CNT_ONE);
    assign fire = qev & last;

    // Arming edge, occurrence counter, one-shot and sequence state
    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            arm_q <= ctrl.arm;

            if (arm_rise)
                cnt_q <= load_val;
            else if (qev)
                cnt_q <= last ? ((act == ACT_REARM) ? load_val : '0) : cnt_q - CNT_ONE;

            if (!ctrl.arm)
                done_q <= 1'b0;
            else if (fire && act != ACT_REARM)
                done_q <= 1'b1;

            if (!ctrl.arm)
                pend_q <= 1'b0;
            else if (active && ctrl.mode == MODE_SEQ) begin
                if (pend_q && hits.bp2_fetch)
                    pend_q <= 1'b0;
                else if (hits.bp1)
                    pend_q <= 1'b1;
            end
        end
    end

    // Action outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_core <= 1'b0;
            fifo_halt <= 1'b0;
            irq       <= 1'b0;
            de_pin    <= 1'b0;
        end else begin
            if (fire && act == ACT_HALT)
                halt_core <= 1'b1;
            else if (clr)
                halt_core <= 1'b0;

            if (fire && act == ACT_FIFO)
                fifo_halt <= 1'b1;
            else if (clr)
                fifo_halt <= 1'b0;

            irq <= fire && (act == ACT_IRQ);

            if (fire && act == ACT_REARM)
                de_pin <= ~de_pin;
        end
    end

    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (halt_core && !clr) |=> halt_core);

    a_r9_fifo_sticky: assert property (@(posedge clk) disable iff (rst)
        (fifo_halt && !clr) |=> fifo_halt);

    a_r11_de_rearm_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(de_pin) |-> ($past(ctrl.act) == ACT_REARM));

    a_r6_pend_cleared: assert property (@(posedge clk) disable iff (rst)
        !ctrl.arm |=> !pend_q);

    a_r12_one_shot: assert property (@(posedge clk) disable iff (rst)
        (fire && act != ACT_REARM) |=> !fire);

    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (qev && !arm_rise && !last) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    a_r7_fire_armed: assert property (@(posedge clk) disable iff (rst)
        fire |-> (arm_q && cnt_q != '0));

endmodule

// File: rtl/bkpt_trigger.sv
module bkpt_trigger
    import bkpt_pkg::*;
#(
    parameter int AW = 16,   // must not exceed DW
    parameter int DW = 16,   // at least 16 to hold the control word
    parameter int CW = 8     // must not exceed DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [AW-1:0] pab,
    input  logic          fetch_stb,
    input  logic [AW-1:0] xab,
    input  logic [DW-1:0] xdb,
    input  logic          rd_stb,
    input  logic          wr_stb,
    output logic          halt_core,
    output logic          fifo_halt,
    output logic          irq,
    output logic          de_pin
);

    logic [AW-1:0] addr_a, addr_b;
    logic [DW-1:0] dval, dmask;
    logic [CW-1:0] count;
    ctrl_t         ctrl;
    logic          clr;
    hits_t         hits;

    bkpt_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .addr_a(addr_a), .addr_b(addr_b), .dval(dval), .dmask(dmask),
        .ctrl(ctrl), .count(count), .clr(clr)
    );

    bkpt_match #(.AW(AW), .DW(DW)) u_match (
        .pab(pab), .fetch_stb(fetch_stb), .xab(xab), .xdb(xdb),
        .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr_a(addr_a), .addr_b(addr_b), .dval(dval), .dmask(dmask),
        .bsel(ctrl.bsel), .acc(ctrl.acc), .hits(hits)
    );

    bkpt_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl), .count(count), .clr(clr), .hits(hits),
        .halt_core(halt_core), .fifo_halt(fifo_halt), .irq(irq), .de_pin(de_pin)
    );

endmodule

// File: tb/bkpt_trigger_test.sv
`timescale 1ns/1ps
module bkpt_trigger_test;
    import bkpt_pkg::*;

    localparam int AW = 16, DW = 16, CW = 8;
    localparam logic [15:0] A_ADR = 16'h0100;
    localparam logic [15:0] B_ADR = 16'h0200;

    logic          clk = 1'b0, rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [AW-1:0] pab = '0, xab = '0;
    logic [DW-1:0] xdb = '0;
    logic          fetch_stb = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic          halt_core, fifo_halt, irq, de_pin;

    int n_cmp = 0, n_bad = 0;
    logic de_exp = 1'b0;

    always #2 clk = ~clk;

    bkpt_trigger #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pab(pab), .fetch_stb(fetch_stb), .xab(xab), .xdb(xdb),
        .rd_stb(rd_stb), .wr_stb(wr_stb),
        .halt_core(halt_core), .fifo_halt(fifo_halt), .irq(irq), .de_pin(de_pin)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // Inputs change one time unit after a rising edge, and outputs are sampled there too.
    task automatic cfg(logic [2:0] a, logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic bus(logic [15:0] p, logic f, logic [15:0] xa, logic [15:0] xd,
                       logic r, logic w);
        pab = p; fetch_stb = f; xab = xa; xdb = xd; rd_stb = r; wr_stb = w;
        @(posedge clk); #1;
        fetch_stb = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    function automatic logic [15:0] mk(logic [1:0] bs, logic [1:0] ac, logic [2:0] md,
                                       act_e at, logic arm);
        return {3'b000, arm, 2'b00, at, 1'b0, md, ac, bs};
    endfunction

    task automatic setup(logic [1:0] bs, logic [1:0] ac, logic [2:0] md, act_e at,
                         logic [7:0] n);
        cfg(REG_CTRL, mk(bs, ac, md, at, 1'b0));
        cfg(REG_CLEAR, 16'h0);
        cfg(REG_COUNT, {8'h00, n});
        cfg(REG_CTRL, mk(bs, ac, md, at, 1'b1));
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int first, hits;
        logic exp;
        logic [15:0] v;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state and off mode
        check("R1 halt_core", halt_core, 0);
        check("R1 fifo_halt", fifo_halt, 0);
        check("R1 irq", irq, 0);
        check("R1 de_pin", de_pin, 0);
        bus(16'h0, 1'b1, 16'h0, 16'h0, 1'b1, 1'b1);
        check("R1 off mode irq", irq, 0);
        check("R1 off mode halt", halt_core, 0);

        cfg(REG_ADDR_A, A_ADR);
        cfg(REG_ADDR_B, B_ADR);

        // R2: data-bus access qualifier sweep (kind 0 read, 1 write, 2 none)
        for (int ac = 0; ac < 4; ac++) begin
            for (int kind = 0; kind < 3; kind++) begin
                setup(2'b10, 2'(ac), MODE_PROG2, ACT_IRQ, 8'd1);
                bus(16'h0, 1'b0, A_ADR, 16'h0, kind == 0, kind == 1);
                exp = (kind == 0 && ac[0]) || (kind == 1 && ac[1]);
                check($sformatf("R2 data acc=%0d kind=%0d", ac, kind), irq, exp);
            end
        end
        setup(2'b10, 2'b11, MODE_PROG2, ACT_IRQ, 8'd1);
        bus(16'h0, 1'b0, A_ADR + 16'h1, 16'h0, 1'b1, 1'b1);
        check("R2 wrong data address", irq, 0);
        // R2: program-bus breakpoint 1, where a fetch is a read
        for (int ac = 0; ac < 4; ac++) begin
            setup(2'b01, 2'(ac), MODE_PROG2, ACT_IRQ, 8'd1);
            bus(A_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
            check($sformatf("R2 prog acc=%0d", ac), irq, ac[0]);
        end
        setup(2'b10, 2'b11, MODE_PROG2, ACT_IRQ, 8'd1);
        bus(A_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        check("R2 program bus not selected", irq, 0);

        // R3: breakpoint 2 ignores the qualifiers
        setup(2'b00, 2'b00, MODE_PROG2, ACT_IRQ, 8'd1);
        bus(16'h0, 1'b0, B_ADR, 16'h0, 1'b1, 1'b1);
        check("R3 data access at B no match", irq, 0);
        bus(B_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        check("R3 fetch at B matches", irq, 1);

        // R4: exact data value match
        cfg(REG_DVAL, 16'h5A5A);
        for (int i = 0; i <= 16; i++) begin
            v = (i == 16) ? 16'h5A5A : (16'h5A5A ^ (16'h1 << i));
            setup(2'b10, 2'b11, MODE_DVAL, ACT_IRQ, 8'd1);
            bus(16'h0, 1'b0, A_ADR, v, 1'b1, 1'b0);
            check($sformatf("R4 value %0h", v), irq, i == 16);
        end
        setup(2'b10, 2'b11, MODE_DVAL, ACT_IRQ, 8'd1);
        bus(16'h0, 1'b0, A_ADR + 16'h4, 16'h5A5A, 1'b1, 1'b0);
        check("R4 right value wrong address", irq, 0);

        // R5: masked match, swept over all 8-bit values
        cfg(REG_DVAL, 16'h0030);
        cfg(REG_DMASK, 16'h00F0);
        for (int x = 0; x < 256; x++) begin
            setup(2'b10, 2'b11, MODE_DMASK, ACT_IRQ, 8'd1);
            bus(16'h0, 1'b0, A_ADR, 16'(x), 1'b0, 1'b1);
            exp = ((x ^ 'h30) & 'hF0) == 0;
            check($sformatf("R5 value %0h", x), irq, exp);
        end

        // R6: sequence ordering
        setup(2'b10, 2'b01, MODE_SEQ, ACT_IRQ, 8'd1);
        bus(B_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        check("R6 bp2 before bp1 ignored", irq, 0);
        bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b1, 1'b0);
        check("R6 bp1 alone", irq, 0);
        bus(B_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        check("R6 bp1 then bp2 fires", irq, 1);

        setup(2'b10, 2'b01, MODE_SEQ, ACT_IRQ, 8'd1);
        bus(B_ADR, 1'b1, A_ADR, 16'h0, 1'b1, 1'b0);
        check("R6 same cycle is first step only", irq, 0);
        bus(B_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        check("R6 later bp2 completes", irq, 1);

        setup(2'b10, 2'b01, MODE_SEQ, ACT_IRQ, 8'd1);
        bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b1, 1'b0);
        cfg(REG_CTRL, mk(2'b10, 2'b01, MODE_SEQ, ACT_IRQ, 1'b0));
        cfg(REG_CTRL, mk(2'b10, 2'b01, MODE_SEQ, ACT_IRQ, 1'b1));
        bus(B_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        check("R6 disarm clears pending", irq, 0);

        // R7 and R12: Nth occurrence fires exactly once
        for (int n = 0; n < 6; n++) begin
            setup(2'b10, 2'b01, MODE_PROG2, ACT_IRQ, 8'(n));
            first = 0; hits = 0;
            for (int k = 1; k <= 7; k++) begin
                bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b1, 1'b0);
                if (irq) begin
                    hits++;
                    if (first == 0) first = k;
                end
            end
            check($sformatf("R7 count %0d fires on event", n), first, (n == 0) ? 1 : n);
            check($sformatf("R12 count %0d fires once", n), hits, 1);
        end

        // R8: sticky halt
        setup(2'b10, 2'b11, MODE_PROG2, ACT_HALT, 8'd1);
        check("R8 halt clear before event", halt_core, 0);
        bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b0, 1'b1);
        check("R8 halt set", halt_core, 1);
        check("R8 no fifo halt", fifo_halt, 0);
        check("R8 no irq", irq, 0);
        repeat (3) idle();
        check("R8 halt held", halt_core, 1);
        cfg(REG_CLEAR, 16'h0);
        check("R8 halt cleared", halt_core, 0);

        // R9: sticky FIFO halt
        setup(2'b10, 2'b11, MODE_PROG2, ACT_FIFO, 8'd1);
        bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b1, 1'b0);
        check("R9 fifo set", fifo_halt, 1);
        check("R9 core not halted", halt_core, 0);
        repeat (3) idle();
        check("R9 fifo held", fifo_halt, 1);
        cfg(REG_CLEAR, 16'h0);
        check("R9 fifo cleared", fifo_halt, 0);

        // R10: one-cycle interrupt
        setup(2'b10, 2'b11, MODE_PROG2, ACT_IRQ, 8'd1);
        bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b1, 1'b0);
        check("R10 irq high", irq, 1);
        idle();
        check("R10 irq low next cycle", irq, 0);

        // R11: rearm toggles de_pin every Nth event
        setup(2'b10, 2'b01, MODE_PROG2, ACT_REARM, 8'd2);
        for (int k = 1; k <= 6; k++) begin
            bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b1, 1'b0);
            if (k % 2 == 0) de_exp = ~de_exp;
            check($sformatf("R11 de after event %0d", k), de_pin, de_exp);
        end
        // R11: rearm returns the sequence to idle
        setup(2'b10, 2'b01, MODE_SEQ, ACT_REARM, 8'd1);
        bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b1, 1'b0);
        bus(B_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        de_exp = ~de_exp;
        check("R11 seq first toggle", de_pin, de_exp);
        bus(B_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        check("R11 seq idle after rearm", de_pin, de_exp);
        bus(16'h0, 1'b0, A_ADR, 16'h0, 1'b1, 1'b0);
        bus(B_ADR, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
        de_exp = ~de_exp;
        check("R11 seq second toggle", de_pin, de_exp);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule